// File: doc/BRIEF.md
# T1 to E1 Rate Frame Mapper

This block places the contents of a 1.544 Mb/s frame, one framing bit plus 24 channel bytes, into a 2.048 Mb/s frame of 32 eight-bit timeslots. It serves a system bus that runs at the higher rate. The block advances one output bit per clock. The upstream logic loads one input frame at a time over a byte-wide write port. It flags the first byte of a frame with a start marker and supplies the frame's framing bit alongside that first byte. Out of the block come a serial bit stream and a one-bit-wide frame sync pulse.

The channel bytes are held in two banks. One bank is filled while the other is read. A filled bank is taken over at the next output frame boundary. If no complete frame is waiting at the boundary, the last frame is sent again.

A two-bit mode input picks one of three layouts:
- Split: a gap at timeslot 16. The framing bit of the frame being loaded goes out one output frame ahead of its channel data.
- Filler: a zero byte in front of every three channels.
- Continuous: the channels are packed into timeslots 1 to 24.

The fourth mode code gives an all-zero frame. The block does not adapt rates. Each input frame is expected to be loaded before the output frame that carries it begins.

Top module: `t1e1_mapper`

## Requirements
- R1: With `map_mode` = 2'b00 (split), channel bytes 1 to 15 appear in timeslots 1 to 15, and channel bytes 16 to 24 appear in timeslots 17 to 25.
- R2: In split mode, bit 0 of timeslot 26 (the first bit sent in that slot) carries the framing bit of the frame that has been completely loaded but not yet taken over. That is the frame whose channels go out in the next output frame. The bit is 0 when no such frame is waiting.
- R3: In split mode, timeslots 0, 16 and 27 to 31 are all zero, and so are the last seven bits of timeslot 26.
- R4: With `map_mode` = 2'b01 (filler), every timeslot 4k is zero except for the framing bit noted in R5. Timeslots 4k+1, 4k+2 and 4k+3 carry channels 3k+1, 3k+2 and 3k+3, for k from 0 to 7.
- R5: In filler mode, frame bit 8 (the last bit of timeslot 0) carries the framing bit of the frame whose channels are in the current output frame.
- R6: With `map_mode` = 2'b10 (continuous), channels 1 to 24 fill timeslots 1 to 24. Bit 8 carries the current frame's framing bit. The first seven bits and timeslots 25 to 31 are zero.
- R7: `fsync` is high for exactly one clock in every 256, on the first bit of timeslot 0. Bits go out MSB first within each timeslot. `ser_out` and `fsync` are registered, so they show the frame position of the previous clock edge.
- R8: `map_mode` = 2'b11 is reserved and drives `ser_out` to 0 for every bit.
- R9: A write with `wr_sof` high stores `wr_data` as channel 1 and captures `wr_fbit`. The next 23 writes store channels 2 to 24, and further writes are ignored. A frame completed during output frame k is carried in frame k+1. A frame that is incomplete at the boundary is not taken over, and the previous frame repeats.
- R10: While `rst` is high, `ser_out` and `fsync` are 0 and both banks and framing bits are cleared. The first clock edge after reset sends bit 0 of a frame with `fsync` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock at the output rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Channel byte write strobe |
| wr_sof | input | 1 | Marks the write carrying channel 1 |
| wr_fbit | input | 1 | Framing bit, captured when `wr_sof` is set |
| wr_data | input | 8 | Channel byte |
| map_mode | input | 2 | 00 split, 01 filler, 10 continuous, 11 reserved |
| ser_out | output | 1 | Serial output bit stream |
| fsync | output | 1 | Output frame sync, first bit of timeslot 0 |

## Verification
A wrong frame position shows up within one clock. `fsync` moves away from its 256-bit spacing, and every channel bit shifts its slot. A wrong bank selection or a missed takeover repeats or mixes channel data. That appears in the first channel timeslot of the next output frame. A stale or early framing bit is only visible at bit 8, or at timeslot 26 in split mode. For that reason the bench changes the framing bit between consecutive frames and compares every bit of every frame.

// File: rtl/t1e1_pkg.sv
package t1e1_pkg;

    localparam int CH_N       = 24;
    localparam int TS_N       = 32;
    localparam int BW         = 8;
    localparam int FRAME_BITS = TS_N * BW;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int CH_W       = $clog2(CH_N);

    localparam int SPLIT_LO_END = 15;
    localparam int SPLIT_HI_BEG = 17;
    localparam int SPLIT_HI_END = 25;
    localparam int SPLIT_F_TS   = 26;
    localparam int FILL_GROUP   = 4;

    typedef enum logic [1:0] {
        MAP_SPLIT  = 2'b00,
        MAP_FILLER = 2'b01,
        MAP_CONT   = 2'b10,
        MAP_RSVD   = 2'b11
    } map_mode_e;

    typedef enum logic [1:0] {
        SRC_ZERO,
        SRC_CHAN,
        SRC_FCUR,
        SRC_FNXT
    } src_kind_e;

    typedef struct packed {
        src_kind_e       kind;
        logic [CH_W-1:0] ch;
        logic [2:0]      bsel;
    } slot_src_t;

    // Where the bit at frame position pos comes from, for a given layout.
    function automatic slot_src_t locate(map_mode_e m, logic [POS_W-1:0] pos);
        slot_src_t s;
        int ts;
        int b;
        ts     = int'(pos) / BW;
        b      = int'(pos) % BW;
        s.kind = SRC_ZERO;
        s.ch   = '0;
        s.bsel = 3'(BW - 1 - b);
        case (m)
            MAP_SPLIT: begin
                if (ts >= 1 && ts <= SPLIT_LO_END) begin
                    s.kind = SRC_CHAN;
                    s.ch   = CH_W'(ts - 1);
                end else if (ts >= SPLIT_HI_BEG && ts <= SPLIT_HI_END) begin
                    s.kind = SRC_CHAN;
                    s.ch   = CH_W'(ts - 2);
                end else if (ts == SPLIT_F_TS && b == 0) begin
                    s.kind = SRC_FNXT;
                end
            end
            MAP_FILLER: begin
                if (ts % FILL_GROUP == 0) begin
                    if (ts == 0 && b == BW - 1) s.kind = SRC_FCUR;
                end else begin
                    s.kind = SRC_CHAN;
                    s.ch   = CH_W'((ts / FILL_GROUP) * (FILL_GROUP - 1)
                                   + (ts % FILL_GROUP) - 1);
                end
            end
            MAP_CONT: begin
                if (ts == 0 && b == BW - 1) begin
                    s.kind = SRC_FCUR;
                end else if (ts >= 1 && ts <= CH_N) begin
                    s.kind = SRC_CHAN;
                    s.ch   = CH_W'(ts - 1);
                end
            end
            default: s.kind = SRC_ZERO;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/t1e1_bit_timer.sv
module t1e1_bit_timer #(
    parameter int FRAME_BITS = 256,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [POS_W-1:0] pos,
    output logic             frame_end
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

    assign frame_end = (pos == LAST);

    always_ff @(posedge clk) begin
        if (rst)            pos <= '0;
        else if (frame_end) pos <= '0;
        else                pos <= pos + 1'b1;
    end

    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (pos == LAST) |=> (pos == '0));

    assert_step_R7: assert property (@(posedge clk) disable iff (rst)
        (pos != LAST) |=> (pos == $past(pos) + 1'b1));

endmodule

// File: rtl/t1e1_frame_store.sv
module t1e1_frame_store #(
    parameter int CH_N    = 24,
    parameter int BW      = 8,
    localparam int CH_W   = $clog2(CH_N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_sof,
    input  logic            wr_fbit,
    input  logic [BW-1:0]   wr_data,
    input  logic            swap_req,
    input  logic [CH_W-1:0] rd_ch,
    output logic [BW-1:0]   rd_byte,
    output logic            fbit_cur,
    output logic            fbit_next
);
    logic [BW-1:0]   mem [2][CH_N];
    logic            rd_bank;
    logic            pending;
    logic            fbit_nxt_q;
    logic [CH_W-1:0] widx;
    logic [CH_W-1:0] idx;

    assign idx       = wr_sof ? '0 : widx;
    assign rd_byte   = mem[rd_bank][rd_ch];
    assign fbit_next = pending & fbit_nxt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int bk = 0; bk < 2; bk++)
                for (int c = 0; c < CH_N; c++)
                    mem[bk][c] <= '0;
            rd_bank    <= 1'b0;
            pending    <= 1'b0;
            fbit_nxt_q <= 1'b0;
            fbit_cur   <= 1'b0;
            widx       <= '0;
        end else begin
            if (wr_en) begin
                if (wr_sof) begin
                    fbit_nxt_q <= wr_fbit;
                    pending    <= 1'b0;
                end
                if (int'(idx) < CH_N) begin
                    mem[~rd_bank][idx] <= wr_data;
                    widx               <= idx + 1'b1;
                    if (int'(idx) == CH_N - 1) pending <= 1'b1;
                end
            end
            if (swap_req && pending) begin
                rd_bank  <= ~rd_bank;
                fbit_cur <= fbit_nxt_q;
                pending  <= 1'b0;
            end
        end
    end

    assert_fill_done_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sof && int'(widx) == CH_N - 1 && !swap_req) |=> pending);

    assert_take_over_R9: assert property (@(posedge clk) disable iff (rst)
        (swap_req && pending && !wr_en) |=> (rd_bank != $past(rd_bank)));

    assert_hold_bank_R9: assert property (@(posedge clk) disable iff (rst)
        (!swap_req) |=> $stable(rd_bank));

endmodule

// File: rtl/t1e1_mapper.sv
module t1e1_mapper
    import t1e1_pkg::*;
#(
    parameter int DATA_W = BW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sof,
    input  logic              wr_fbit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        map_mode,
    output logic              ser_out,
    output logic              fsync
);
    logic [POS_W-1:0]  pos;
    logic              frame_end;
    logic [DATA_W-1:0] rd_byte;
    logic              fbit_cur;
    logic              fbit_next;
    slot_src_t         src;
    logic              bit_val;

    t1e1_bit_timer #(.FRAME_BITS(FRAME_BITS)) timer_i (
        .clk       (clk),
        .rst       (rst),
        .pos       (pos),
        .frame_end (frame_end)
    );

    assign src = locate(map_mode_e'(map_mode), pos);

    t1e1_frame_store #(.CH_N(CH_N), .BW(DATA_W)) store_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sof    (wr_sof),
        .wr_fbit   (wr_fbit),
        .wr_data   (wr_data),
        .swap_req  (frame_end),
        .rd_ch     (src.ch),
        .rd_byte   (rd_byte),
        .fbit_cur  (fbit_cur),
        .fbit_next (fbit_next)
    );

    always_comb begin
        case (src.kind)
            SRC_CHAN: bit_val = rd_byte[src.bsel];
            SRC_FCUR: bit_val = fbit_cur;
            SRC_FNXT: bit_val = fbit_next;
            default:  bit_val = 1'b0;
        endcase
    end

    always_comb begin
        if (src.kind == SRC_CHAN)
            assert_ch_range_R1: assert (int'(src.ch) < CH_N);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_out <= 1'b0;
            fsync   <= 1'b0;
        end else begin
            ser_out <= bit_val;
            fsync   <= (pos == '0);
        end
    end

    assert_sync_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        fsync |=> !fsync);

    assert_sync_slot_zero_R7: assert property (@(posedge clk) disable iff (rst)
        fsync |-> !ser_out);

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (map_mode == 2'b11) |=> !ser_out);

endmodule

// File: tb/t1e1_mapper_tb.sv
module t1e1_mapper_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sof = 1'b0;
    logic       wr_fbit = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] map_mode = 2'b00;
    logic       ser_out;
    logic       fsync;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit repeat_phase = 0;

    always #5 clk = ~clk;

    t1e1_mapper dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sof   (wr_sof),
        .wr_fbit  (wr_fbit),
        .wr_data  (wr_data),
        .map_mode (map_mode),
        .ser_out  (ser_out),
        .fsync    (fsync)
    );

    // Behavioural reference
    logic [7:0] cur_ch [24];
    logic [7:0] nxt_ch [24];
    bit cur_f, nxt_f, nxt_v;
    int widx, pos;
    bit exp_ser, exp_fs, model_on;
    int last_mode, last_pos;

    function automatic bit chan_bit(int ch, int b);
        logic [7:0] v;
        v = cur_ch[ch];
        return v[7 - b];
    endfunction

    function automatic bit ref_bit(int m, int p);
        int ts, b;
        ts = p / 8;
        b  = p % 8;
        if (m == 0) begin
            if (ts >= 1 && ts <= 15) return chan_bit(ts - 1, b);
            if (ts >= 17 && ts <= 25) return chan_bit(ts - 2, b);
            if (ts == 26 && b == 0) return nxt_v ? nxt_f : 1'b0;
            return 1'b0;
        end else if (m == 1) begin
            if (ts % 4 == 0) return (p == 7) ? cur_f : 1'b0;
            return chan_bit((ts / 4) * 3 + (ts % 4) - 1, b);
        end else if (m == 2) begin
            if (p == 7) return cur_f;
            if (ts >= 1 && ts <= 24) return chan_bit(ts - 1, b);
            return 1'b0;
        end
        return 1'b0;
    endfunction

    function automatic string req_for(int m, int p);
        if (repeat_phase) return "R9";
        if (m == 3) return "R8";
        if (m == 0) begin
            if (p / 8 == 26 && p % 8 == 0) return "R2";
            if ((p / 8 >= 1 && p / 8 <= 15) || (p / 8 >= 17 && p / 8 <= 25)) return "R1";
            return "R3";
        end
        if (m == 1) return (p == 7) ? "R5" : "R4";
        return "R6";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 24; c++) begin
                cur_ch[c] = 8'h00;
                nxt_ch[c] = 8'h00;
            end
            cur_f = 0; nxt_f = 0; nxt_v = 0;
            widx = 0; pos = 0;
            exp_ser = 0; exp_fs = 0;
            model_on = 1;
        end else begin
            exp_ser   = ref_bit(int'(map_mode), pos);
            exp_fs    = (pos == 0);
            last_mode = int'(map_mode);
            last_pos  = pos;
            if (wr_en) begin
                if (wr_sof) begin
                    widx  = 0;
                    nxt_f = wr_fbit;
                    nxt_v = 0;
                end
                if (widx < 24) begin
                    nxt_ch[widx] = wr_data;
                    widx++;
                    if (widx == 24) nxt_v = 1;
                end
            end
            if (pos == 255) begin
                if (nxt_v) begin
                    for (int c = 0; c < 24; c++) cur_ch[c] = nxt_ch[c];
                    cur_f = nxt_f;
                    nxt_v = 0;
                end
                pos = 0;
            end else begin
                pos++;
            end
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (model_on && !rst) begin
            checks++;
            if (fsync !== exp_fs) begin
                errors++;
                $display("FAIL R7 fsync pos=%0d got %b exp %b", last_pos, fsync, exp_fs);
            end
            checks++;
            if (ser_out !== exp_ser) begin
                errors++;
                $display("FAIL %s ser_out mode=%0d pos=%0d got %b exp %b",
                         req_for(last_mode, last_pos), last_mode, last_pos, ser_out, exp_ser);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic wait_sync();
        @(negedge clk);
        while (fsync !== 1'b1) @(negedge clk);
    endtask

    task automatic load_frame(input int n, input bit f, input int seed);
        for (int i = 0; i < n; i++) begin
            wr_en   = 1'b1;
            wr_sof  = (i == 0);
            wr_fbit = (i == 0) ? f : 1'b0;
            wr_data = 8'(seed * 37 + i * 11 + 5);
            @(negedge clk);
        end
        wr_en  = 1'b0;
        wr_sof = 1'b0;
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (ser_out !== 1'b0 || fsync !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset outputs got %b%b exp 00", ser_out, fsync);
        end
        rst = 1'b0;
        // R10: first edge after reset sends bit 0 with fsync
        @(negedge clk);
        checks++;
        if (fsync !== 1'b1) begin
            errors++;
            $display("FAIL R10 first fsync got %b exp 1", fsync);
        end

        // R1, R2, R3: split mode, framing bit alternates per frame
        map_mode = 2'b00;
        for (int k = 0; k < 4; k++) begin
            load_frame(24, k[0], k + 1);
            wait_sync();
        end
        // R4, R5: filler mode
        map_mode = 2'b01;
        for (int k = 0; k < 3; k++) begin
            load_frame(24, ~k[0], k + 10);
            wait_sync();
        end
        // R6: continuous mode
        map_mode = 2'b10;
        for (int k = 0; k < 3; k++) begin
            load_frame(24, k[0], k + 20);
            wait_sync();
        end
        // R9: incomplete frame is not taken over, previous repeats
        repeat_phase = 1;
        load_frame(10, 1'b1, 40);
        wait_sync();
        wait_sync();
        repeat_phase = 0;
        // R9: extra writes past channel 24 are ignored
        load_frame(30, 1'b0, 50);
        wait_sync();
        // R8: reserved mode
        map_mode = 2'b11;
        load_frame(24, 1'b1, 60);
        wait_sync();
        wait_sync();
        // R2: split with no frame waiting, R9 repeat
        map_mode = 2'b00;
        repeat_phase = 1;
        wait_sync();
        wait_sync();
        repeat_phase = 0;
        @(negedge clk);
        finish_run();
    end

endmodule